// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block receives words from a synchronous serial link on which a remote master drives the serial clock. It samples the incoming clock and data lines into the local clock domain, detects the active clock edge (rising or falling, picked by a polarity control), and assembles 8-bit or 9-bit words least significant bit first in a shift register. Each finished word moves into a holding register, which raises a receive-done flag and, when enabled, an interrupt request.

The interrupt request stays valid while the local core is in a low-power state. Reception does not depend on any local activity beyond the sampling clock, so the request can also serve as a wake-up. Software reads a status byte (ninth bit, overrun, framing, receive-done) and a data byte through a small read port. Reading the data byte clears receive-done. If a second word finishes before the first is read, the block flags an overrun, drops the new word and stops shifting. Dropping the continuous-receive enable clears the error and realigns the bit counter.

Top module: `sss_slave_rx`

## Requirements
- R1: After reset, `rd_q` and `irq` are 0, and a status read returns 0.
- R2: Reception happens only when `sync_mode`=1, `port_en`=1 and `clk_master`=0. Otherwise clock edges assemble no word and the bit counter stays at zero.
- R3: `single_rx_req` has no effect. With `cont_rx_en`=0 no word is received, and with `cont_rx_en`=1 words are received whatever its value.
- R4: Each active clock edge samples one data bit, least significant bit first. After 8 edges (`nine_bit_en`=0) the word is held, status bit 3 (receive-done) reads 1, and a data read (`rd_addr`=0) returns the byte.
- R5: With `nine_bit_en`=1 a word is 9 bits. The ninth bit received is returned in status bit 0, and the data read returns the first 8 bits.
- R6: A data read clears receive-done. A status read (`rd_addr`=1) clears nothing. Read results appear on `rd_q` one clock after the `rd_stb` cycle.
- R7: `irq` equals (receive-done AND `irq_en`), registered one clock later.
- R8: A word that completes while receive-done is still set sets overrun (status bit 1) and is discarded. Later words are ignored while overrun is set, and the held data is kept.
- R9: Clearing `cont_rx_en` clears overrun, the bit counter and the shift register, so a partly received word is thrown away and the next word starts aligned.
- R10: With `sck_invert`=0 the rising edge of `sck_i` is active. With `sck_invert`=1 the falling edge is active.
- R11: The framing-error flag (status bit 2) always reads 0 in this synchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock from the remote master |
| sd_i | input | 1 | Serial data |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master | input | 1 | Clock-source select, 1 = local master (receiver idle) |
| nine_bit_en | input | 1 | 9-bit word length |
| cont_rx_en | input | 1 | Continuous receive enable and error clear |
| single_rx_req | input | 1 | Single-receive request, ignored in slave mode |
| sck_invert | input | 1 | Clock polarity, 1 = falling edge active |
| irq_en | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 1 | 0 = data byte, 1 = status byte |
| rd_q | output | 8 | Registered read data |
| irq | output | 1 | Receive interrupt / wake-up request |

## Verification
The assertions take for granted that the serial clock is much slower than the sampling clock, with each level held for at least two local cycles, so that the two-stage synchronizers never merge or miss an edge. They also assume a completed word never meets a data read in the same cycle. The stimulus holds each serial clock level for four local cycles and changes data only while the clock is at its idle level. Reads are issued only after a word has settled, either by waiting for `irq` or by waiting a fixed time after the last bit.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam logic RD_DATA   = 1'b0;
  localparam logic RD_STATUS = 1'b1;
  localparam int ST_NINTH = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_FRM   = 2;
  localparam int ST_DONE  = 3;
endpackage

// File: rtl/sss_edge_detect.sv
module sss_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic sd_i,
  input  logic invert,
  output logic act_edge,
  output logic sd_sync
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sck_sync;
  logic [MSB:0] sd_pipe;
  logic         sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sync <= '0;
      sd_pipe  <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[MSB-1:0], sck_i};
      sd_pipe  <= {sd_pipe[MSB-1:0], sd_i};
      sck_prev <= sck_sync[MSB];
    end
  end

  // Polarity folded in before the edge compare: inverted clock turns a fall into a rise
  assign act_edge = (sck_sync[MSB] ^ invert) & ~(sck_prev ^ invert);
  assign sd_sync  = sd_pipe[MSB];
endmodule

// File: rtl/sss_shifter.sv
module sss_shifter #(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1,
  localparam int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              nine,
  input  logic              act_edge,
  input  logic              sd,
  output logic              word_done,
  output logic [WORD_W-1:0] word_q,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] assembled;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx = nine ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

  always_comb begin
    assembled = shreg;
    assembled[bit_cnt[$clog2(WORD_W)-1:0]] = sd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      word_done <= 1'b0;
      word_q    <= '0;
    end else begin
      word_done <= 1'b0;
      if (!run) begin
        shreg   <= '0;
        bit_cnt <= '0;
      end else if (act_edge) begin
        if (bit_cnt == last_idx) begin
          word_done <= 1'b1;
          word_q    <= assembled;
          shreg     <= '0;
          bit_cnt   <= '0;
        end else begin
          shreg   <= assembled;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sss_rx_regs.sv
module sss_rx_regs
  import sss_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  input  logic              nine,
  input  logic              clr_err,
  input  logic              rd_stb,
  input  logic              rd_addr,
  input  logic              irq_en,
  output logic [DATA_W-1:0] rd_q,
  output logic              irq,
  output logic              rx_full,
  output logic              overrun
);
  logic [DATA_W-1:0] hold_q;
  logic              ninth_q;
  logic              data_rd;
  logic              full_eff;
  logic              load;
  logic [DATA_W-1:0] status_vec;

  assign data_rd  = rd_stb && (rd_addr == RD_DATA);
  assign full_eff = rx_full && !data_rd;
  assign load     = word_done && !full_eff;

  always_comb begin
    status_vec           = '0;
    status_vec[ST_NINTH] = ninth_q;
    status_vec[ST_OVR]   = overrun;
    status_vec[ST_FRM]   = 1'b0;
    status_vec[ST_DONE]  = rx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      ninth_q <= 1'b0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
      rd_q    <= '0;
      irq     <= 1'b0;
    end else begin
      if (load) begin
        hold_q  <= word[DATA_W-1:0];
        ninth_q <= nine & word[DATA_W];
      end
      rx_full <= load || full_eff;
      if (clr_err)
        overrun <= 1'b0;
      else if (word_done && full_eff)
        overrun <= 1'b1;
      if (rd_stb)
        rd_q <= data_rd ? hold_q : status_vec;
      irq <= rx_full && irq_en;
    end
  end
endmodule

// File: rtl/sss_slave_rx.sv
module sss_slave_rx #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              sd_i,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_master,
  input  logic              nine_bit_en,
  input  logic              cont_rx_en,
  input  logic              single_rx_req,
  input  logic              sck_invert,
  input  logic              irq_en,
  input  logic              rd_stb,
  input  logic              rd_addr,
  output logic [DATA_W-1:0] rd_q,
  output logic              irq
);
  localparam int WORD_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic              active;
  logic              run;
  logic              act_edge;
  logic              sd_sync;
  logic              word_done;
  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic              rx_full;
  logic              overrun;
  logic              unused_req;

  // The single-receive request does not take part in slave reception
  assign unused_req = single_rx_req;

  assign active = port_en && sync_mode && !clk_master;
  assign run    = active && cont_rx_en && !overrun;

  sss_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .sck_i    (sck_i),
    .sd_i     (sd_i),
    .invert   (sck_invert),
    .act_edge (act_edge),
    .sd_sync  (sd_sync)
  );

  sss_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .nine      (nine_bit_en),
    .act_edge  (act_edge),
    .sd        (sd_sync),
    .word_done (word_done),
    .word_q    (word_q),
    .bit_cnt   (bit_cnt)
  );

  sss_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .word      (word_q),
    .nine      (nine_bit_en),
    .clr_err   (!(active && cont_rx_en)),
    .rd_stb    (rd_stb),
    .rd_addr   (rd_addr),
    .irq_en    (irq_en),
    .rd_q      (rd_q),
    .irq       (irq),
    .rx_full   (rx_full),
    .overrun   (overrun)
  );
endmodule

// File: rtl/sss_checker.sv
module sss_checker (
  input logic clk,
  input logic rst,
  input logic active,
  input logic cont_rx_en,
  input logic word_done,
  input logic rx_full,
  input logic overrun,
  input logic irq,
  input logic irq_en,
  input logic rd_stb,
  input logic rd_addr,
  input logic cnt_zero
);
  // R7
  a_r7_irq_follows_done: assert property (@(posedge clk) disable iff (rst)
    irq == $past(rx_full && irq_en));

  // R8
  a_r8_no_word_in_overrun: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !word_done);

  // R2
  a_r2_idle_when_inactive: assert property (@(posedge clk) disable iff (rst)
    !active |=> cnt_zero);

  // R6
  a_r6_data_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !rd_addr && !word_done) |=> !rx_full);

  // R4
  a_r4_word_sets_done: assert property (@(posedge clk) disable iff (rst)
    (word_done && !rx_full) |=> rx_full);

  // R9
  a_r9_disable_clears_ovr: assert property (@(posedge clk) disable iff (rst)
    !cont_rx_en |=> !overrun);
endmodule

bind sss_slave_rx sss_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .active     (active),
  .cont_rx_en (cont_rx_en),
  .word_done  (word_done),
  .rx_full    (rx_full),
  .overrun    (overrun),
  .irq        (irq),
  .irq_en     (irq_en),
  .rd_stb     (rd_stb),
  .rd_addr    (rd_addr),
  .cnt_zero   (bit_cnt == '0)
);

// File: tb/tb_sss_slave_rx.sv
module tb_sss_slave_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_i = 1'b0, sd_i = 1'b0;
  logic port_en = 1'b0, sync_mode = 1'b0, clk_master = 1'b0;
  logic nine_bit_en = 1'b0, cont_rx_en = 1'b0, single_rx_req = 1'b0;
  logic sck_invert = 1'b0, irq_en = 1'b0, rd_stb = 1'b0, rd_addr = 1'b0;
  logic [7:0] rd_q;
  logic irq;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  sss_slave_rx dut (
    .clk(clk), .rst(rst), .sck_i(sck_i), .sd_i(sd_i), .port_en(port_en),
    .sync_mode(sync_mode), .clk_master(clk_master), .nine_bit_en(nine_bit_en),
    .cont_rx_en(cont_rx_en), .single_rx_req(single_rx_req), .sck_invert(sck_invert),
    .irq_en(irq_en), .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_q(rd_q), .irq(irq)
  );

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    rd_stb  = 1'b1;
    @(negedge clk);
    rd_stb  = 1'b0;
    v = rd_q;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sd_i  = b;
    sck_i = sck_invert;
    repeat (4) @(negedge clk);
    sck_i = ~sck_invert;
    repeat (4) @(negedge clk);
    sck_i = sck_invert;
  endtask

  // Driver: optionally records the word the monitor must see
  task automatic send_word(input logic [8:0] w, input bit expect_it);
    if (expect_it) exp_q.push_back(nine_bit_en ? w : {1'b0, w[7:0]});
    for (int i = 0; i < (nine_bit_en ? 9 : 8); i++) send_bit(w[i]);
    repeat (8) @(negedge clk);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
  endtask

  // Monitor: on each interrupt, reads status then data and compares with the queue
  initial begin
    logic [7:0] st, dt;
    logic [8:0] e;
    forever begin
      @(posedge irq);
      read_reg(1'b1, st);
      read_reg(1'b0, dt);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4: unexpected word %h, expected none", dt);
      end else begin
        e = exp_q.pop_front();
        check("R5 status ninth/done", {1'b0, st}, {1'b0, 7'b0000100, e[8]});
        check("R4 data byte", {1'b0, dt}, {1'b0, e[7:0]});
        repeat (2) @(negedge clk);
        check("R7 irq drops after data read", {8'b0, irq}, 9'h0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_q", {1'b0, rd_q}, 9'h0);
    check("R1 irq", {8'b0, irq}, 9'h0);
    read_reg(1'b1, v);
    check("R1 status", {1'b0, v}, 9'h0);

    port_en = 1; sync_mode = 1; clk_master = 0; cont_rx_en = 1; irq_en = 1;
    // R4, R10 rising edge
    send_word(9'h0A5, 1); send_word(9'h001, 1); send_word(9'h080, 1);
    drain();
    // R5 nine-bit words
    nine_bit_en = 1;
    send_word(9'h13C, 1); send_word(9'h0C3, 1);
    drain();
    nine_bit_en = 0;
    // R10 falling edge active
    @(negedge clk); sck_invert = 1; sck_i = 1;
    repeat (6) @(negedge clk);
    send_word(9'h05A, 1);
    drain();
    @(negedge clk); sck_invert = 0; sck_i = 0;
    repeat (6) @(negedge clk);

    // R3 single request ignored without continuous enable
    cont_rx_en = 0; single_rx_req = 1;
    send_word(9'h0FF, 0);
    read_reg(1'b1, v);
    check("R3 no word with single request only", {1'b0, v}, 9'h0);
    cont_rx_en = 1;
    send_word(9'h03C, 1);
    drain();
    single_rx_req = 0;
    // R2 inactive configurations
    clk_master = 1;
    send_word(9'h0F0, 0);
    read_reg(1'b1, v);
    check("R2 clock master selected", {1'b0, v}, 9'h0);
    clk_master = 0; sync_mode = 0;
    send_word(9'h0F0, 0);
    read_reg(1'b1, v);
    check("R2 async mode selected", {1'b0, v}, 9'h0);
    sync_mode = 1; port_en = 0;
    send_word(9'h0F0, 0);
    read_reg(1'b1, v);
    check("R2 port disabled", {1'b0, v}, 9'h0);
    port_en = 1;

    // R9 partial word thrown away by disable
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    repeat (4) @(negedge clk);
    cont_rx_en = 0;
    repeat (4) @(negedge clk);
    cont_rx_en = 1;
    send_word(9'h096, 1);
    drain();

    // R7, R6, R8, R11 with interrupts off
    irq_en = 0;
    send_word(9'h011, 0);
    check("R7 irq held low when disabled", {8'b0, irq}, 9'h0);
    read_reg(1'b1, v);
    check("R6 status shows done", {1'b0, v}, 9'h008);
    read_reg(1'b1, v);
    check("R6 status read does not clear", {1'b0, v}, 9'h008);
    send_word(9'h022, 0);
    read_reg(1'b1, v);
    check("R8 overrun set, R11 framing 0", {1'b0, v}, 9'h00A);
    send_word(9'h044, 0);
    read_reg(1'b0, v);
    check("R8 held data kept", {1'b0, v}, 9'h011);
    read_reg(1'b1, v);
    check("R6 data read clears done", {1'b0, v}, 9'h002);
    cont_rx_en = 0;
    repeat (3) @(negedge clk);
    read_reg(1'b1, v);
    check("R9 overrun cleared by disable", {1'b0, v}, 9'h000);
    cont_rx_en = 1;
    irq_en = 1;
    send_word(9'h033, 1);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule